// File: doc/BRIEF.md
# LIN Master Header Transmitter

This block produces the header of a LIN frame on a single serial output line. It runs on the master side. Host logic writes one identifier byte and the block does the rest with no further help. It drives a long dominant break with a short recessive tail, then the sync character, then the identifier character. The identifier can carry two parity bits that the block computes itself.

Bit timing comes from an external baud divider. That divider sends a one-cycle enable pulse per bit period, and the line only moves on those pulses. A ready flag tells the host when the identifier has been taken into the shift register. Two sticky flags record that the break has gone out and that the identifier has gone out; a clear strobe resets both. A separate transmitter reset drops any header in flight and returns the line to idle. This reset is intended for use after the node mode changes.

Top module: `lin_hdr_tx`

## Requirements
- R1: An identifier write starts a header only while `mode_i` equals 4'hA (master); with any other value, e.g. 4'hB (slave), the write is ignored: `txd_o` stays 1, `txrdy_o` stays 1 and no flag sets.
- R2: On the clock edge that samples an accepted identifier write, `txrdy_o` goes to 0 and `txd_o` goes to 0 (first break bit).
- R3: The break is 13 bit periods at 0 followed by 1 bit period at 1; the line advances to the next bit only on a clock edge that samples `baud_tick_i` high.
- R4: Right after the break, the character 0x55 is sent as a start bit 0, eight data bits least significant first, and a stop bit 1.
- R5: The identifier character follows the sync character in the same framing; with `par_en_i` low at the write, the eight written bits are sent unchanged.
- R6: With `par_en_i` high at the write, bits 5:0 are sent as written, bit 6 as ID0^ID1^ID2^ID4 and bit 7 as NOT(ID1^ID3^ID4^ID5).
- R7: `txrdy_o` returns to 1 on the edge that ends the sync stop bit, when the identifier enters the shift register, while its ten bits are still to be shifted.
- R8: `brk_done_o` sets on the edge that ends the break's recessive bit, `id_done_o` on the edge that ends the identifier stop bit; both stay set until cleared.
- R9: A cycle with `sts_clr_i` high clears both flags on its edge, except that a flag whose set event falls in that same cycle ends up set.
- R10: An identifier write while a header is in progress is ignored and does not change the identifier that is sent.
- R11: `tx_rst_i` high returns the engine to idle on the next edge: `txd_o` 1, `txrdy_o` 1, flags unchanged, and later baud pulses move nothing.
- R12: After `rst`, `txd_o` and `txrdy_o` are 1 and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick_i | input | 1 | One-cycle pulse marking the end of a bit period |
| mode_i | input | 4 | Node mode code; 4'hA is master |
| par_en_i | input | 1 | Insert identifier parity bits |
| id_wr_i | input | 1 | Identifier write strobe |
| id_i | input | 8 | Identifier byte written |
| sts_clr_i | input | 1 | Clear both sticky flags |
| tx_rst_i | input | 1 | Transmitter reset: abandon header, go idle |
| txd_o | output | 1 | Serial line, idle 1, dominant 0 |
| txrdy_o | output | 1 | Ready for a new identifier |
| brk_done_o | output | 1 | Sticky: break sent |
| id_done_o | output | 1 | Sticky: identifier sent |

## Verification
An accepted write shows up one edge later as `txd_o` and `txrdy_o` low. After that, each bit is on the line from the edge that samples a baud pulse until the next such edge. `brk_done_o` is due on the 14th pulse edge, `txrdy_o` on the 24th and `id_done_o` on the 34th. The bench drives every input on the falling edge. It raises the baud pulse for exactly one cycle, separated by idle cycles. It samples all outputs on the falling edge before the next pulse, so each sample sits in the middle of one bit. Clears and transmitter resets are sampled one edge after their strobe, and the ignored-write cases are sampled both right after the write and after further pulses.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;
  localparam int ID_W = 8;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_BRK  = 2'd1,
    HS_SYNC = 2'd2,
    HS_PID  = 2'd3
  } hdr_state_t;
endpackage

// File: rtl/lin_pid_gen.sv
module lin_pid_gen
  import lin_hdr_pkg::*;
(
  input  logic            par_en,
  input  logic [ID_W-1:0] id_raw,
  output logic [ID_W-1:0] id_out
);
  logic p_lo, p_hi;
  always_comb begin
    p_lo   = id_raw[0] ^ id_raw[1] ^ id_raw[2] ^ id_raw[4];
    p_hi   = ~(id_raw[1] ^ id_raw[3] ^ id_raw[4] ^ id_raw[5]);
    id_out = par_en ? {p_hi, p_lo, id_raw[5:0]} : id_raw;
  end
endmodule

// File: rtl/lin_hdr_flags.sv
module lin_hdr_flags (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic set_brk,
  input  logic set_id,
  output logic brk_q,
  output logic id_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      brk_q <= 1'b0;
      id_q  <= 1'b0;
    end else begin
      if (set_brk)  brk_q <= 1'b1;
      else if (clr) brk_q <= 1'b0;
      if (set_id)   id_q  <= 1'b1;
      else if (clr) id_q  <= 1'b0;
    end
  end

  assert_brk_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (brk_q && !clr) |=> brk_q);
  assert_id_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (id_q && !clr) |=> id_q);
  assert_clear_wins_unless_set_R9: assert property (@(posedge clk) disable iff (rst)
    (clr && !set_brk && !set_id) |=> (!brk_q && !id_q));
endmodule

// File: rtl/lin_hdr_seq.sv
module lin_hdr_seq
  import lin_hdr_pkg::*;
#(
  parameter int          BRK_LOW   = 13,
  parameter int          BRK_HIGH  = 1,
  parameter logic [7:0]  SYNC_CHAR = 8'h55
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            start,
  input  logic            abort,
  input  logic [ID_W-1:0] pid,
  output logic            txd,
  output logic            txrdy,
  output logic            busy,
  output logic            brk_end,
  output logic            pid_end
);
  localparam int BRK_BITS  = BRK_LOW + BRK_HIGH;
  localparam int CHAR_BITS = ID_W + 2;
  localparam int SH_W      = (BRK_BITS > CHAR_BITS) ? BRK_BITS : CHAR_BITS;
  localparam int LW        = $clog2(SH_W);
  localparam logic [SH_W-1:0] ONES    = {SH_W{1'b1}};
  localparam logic [SH_W-1:0] BRK_PAT = ONES << BRK_LOW;

  function automatic logic [SH_W-1:0] frame(input logic [ID_W-1:0] d);
    logic [SH_W-1:0] f;
    f           = ONES;
    f[ID_W:1]   = d;
    f[0]        = 1'b0;
    return f;
  endfunction

  hdr_state_t      st;
  logic [SH_W-1:0] sh;
  logic [LW-1:0]   left;
  logic [ID_W-1:0] pid_q;
  logic            last;

  assign txd  = sh[0];
  assign busy = (st != HS_IDLE);
  assign last = tick && busy && (left == '0);
  assign brk_end = last && (st == HS_BRK);
  assign pid_end = last && (st == HS_PID);

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      st    <= HS_IDLE;
      sh    <= ONES;
      left  <= '0;
      txrdy <= 1'b1;
      if (rst) pid_q <= '0;
    end else if (start && !busy) begin
      st    <= HS_BRK;
      sh    <= BRK_PAT;
      left  <= LW'(BRK_BITS - 1);
      txrdy <= 1'b0;
      pid_q <= pid;
    end else if (tick && busy) begin
      if (left != '0) begin
        sh   <= {1'b1, sh[SH_W-1:1]};
        left <= left - 1'b1;
      end else begin
        unique case (st)
          HS_BRK: begin
            st   <= HS_SYNC;
            sh   <= frame(SYNC_CHAR);
            left <= LW'(CHAR_BITS - 1);
          end
          HS_SYNC: begin
            st    <= HS_PID;
            sh    <= frame(pid_q);
            left  <= LW'(CHAR_BITS - 1);
            txrdy <= 1'b1;
          end
          default: begin
            st <= HS_IDLE;
            sh <= ONES;
          end
        endcase
      end
    end
  end

  assert_start_goes_dominant_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !abort) |=> (!txd && !txrdy));
  assert_line_holds_between_ticks_R3: assert property (@(posedge clk) disable iff (rst)
    (!tick && !start && !abort) |=> $stable(txd));
  assert_abort_goes_idle_R11: assert property (@(posedge clk) disable iff (rst)
    abort |=> (txd && txrdy && !busy));
endmodule

// File: rtl/lin_hdr_tx.sv
module lin_hdr_tx
  import lin_hdr_pkg::*;
#(
  parameter int         MODE_W      = 4,
  parameter logic [3:0] MASTER_CODE = 4'hA,
  parameter int         BRK_LOW     = 13,
  parameter int         BRK_HIGH    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              par_en_i,
  input  logic              id_wr_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic              sts_clr_i,
  input  logic              tx_rst_i,
  output logic              txd_o,
  output logic              txrdy_o,
  output logic              brk_done_o,
  output logic              id_done_o
);
  logic            busy, accept, brk_end, pid_end;
  logic [ID_W-1:0] pid_w;

  assign accept = id_wr_i && (mode_i == MODE_W'(MASTER_CODE)) && !busy && !tx_rst_i;

  lin_pid_gen u_pid (
    .par_en (par_en_i),
    .id_raw (id_i),
    .id_out (pid_w)
  );

  lin_hdr_seq #(
    .BRK_LOW  (BRK_LOW),
    .BRK_HIGH (BRK_HIGH)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .tick    (baud_tick_i),
    .start   (accept),
    .abort   (tx_rst_i),
    .pid     (pid_w),
    .txd     (txd_o),
    .txrdy   (txrdy_o),
    .busy    (busy),
    .brk_end (brk_end),
    .pid_end (pid_end)
  );

  lin_hdr_flags u_flags (
    .clk     (clk),
    .rst     (rst),
    .clr     (sts_clr_i),
    .set_brk (brk_end),
    .set_id  (pid_end),
    .brk_q   (brk_done_o),
    .id_q    (id_done_o)
  );

  assert_non_master_write_ignored_R1: assert property (@(posedge clk) disable iff (rst)
    (id_wr_i && (mode_i != MODE_W'(MASTER_CODE)) && !busy && !tx_rst_i) |=> (txd_o && txrdy_o));
  assert_busy_write_keeps_low_R10: assert property (@(posedge clk) disable iff (rst)
    (id_wr_i && busy && !txrdy_o && !tx_rst_i && !baud_tick_i) |=> !txrdy_o);
endmodule

// File: tb/tb_lin_hdr_tx.sv
module tb_lin_hdr_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick_i = 1'b0;
  logic [3:0] mode_i = 4'hA;
  logic       par_en_i = 1'b0;
  logic       id_wr_i = 1'b0;
  logic [7:0] id_i = 8'h00;
  logic       sts_clr_i = 1'b0;
  logic       tx_rst_i = 1'b0;
  logic       txd_o, txrdy_o, brk_done_o, id_done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  lin_hdr_tx dut (
    .clk(clk), .rst(rst), .baud_tick_i(baud_tick_i), .mode_i(mode_i),
    .par_en_i(par_en_i), .id_wr_i(id_wr_i), .id_i(id_i), .sts_clr_i(sts_clr_i),
    .tx_rst_i(tx_rst_i), .txd_o(txd_o), .txrdy_o(txrdy_o),
    .brk_done_o(brk_done_o), .id_done_o(id_done_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_pid(input logic [7:0] id, input logic pe);
    logic a, b;
    a = id[0] ^ id[1] ^ id[2] ^ id[4];
    b = !(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return pe ? {b, a, id[5:0]} : id;
  endfunction

  task automatic tick_pulse(input logic clr_too);
    @(negedge clk); baud_tick_i = 1'b1; sts_clr_i = clr_too;
    @(negedge clk); baud_tick_i = 1'b0; sts_clr_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk); sts_clr_i = 1'b1;
    @(negedge clk); sts_clr_i = 1'b0;
  endtask

  task automatic write_id(input logic [7:0] id, input logic pe);
    @(negedge clk); id_wr_i = 1'b1; id_i = id; par_en_i = pe;
    @(negedge clk); id_wr_i = 1'b0;
  endtask

  // Full header: checks every bit, flags and ready at each bit period.
  task automatic t_header(input logic [7:0] id, input logic pe,
                          input bit busy_write, input bit clr_last);
    logic [33:0] exp_bits;
    logic [7:0]  p;
    p = ref_pid(id, pe);
    exp_bits = {1'b1, p, 1'b0, 1'b1, 8'h55, 1'b0, 1'b1, 13'b0};
    clear_flags();
    write_id(id, pe);
    check("R2 txrdy low after write", txrdy_o, 0);
    for (int k = 0; k < 34; k++) begin
      if (k < 14)      check("R3 break bit", txd_o, exp_bits[k]);
      else if (k < 24) check("R4 sync bit", txd_o, exp_bits[k]);
      else             check(pe ? "R6 pid bit" : "R5 id bit", txd_o, exp_bits[k]);
      check("R7 txrdy timing", txrdy_o, (k >= 24) ? 1 : 0);
      check("R8 break flag", brk_done_o, (k >= 14) ? 1 : 0);
      check("R8 id flag early", id_done_o, 0);
      if (busy_write && k == 5) begin
        write_id(~id, ~pe);
        check("R10 busy write txd", txd_o, 0);
        check("R10 busy write txrdy", txrdy_o, 0);
      end
      tick_pulse(clr_last && k == 33);
    end
    check("R8 idle line", txd_o, 1);
    check("R8 id flag set", id_done_o, 1);
    check("R7 txrdy idle", txrdy_o, 1);
    if (clr_last) check("R9 clear beats old break flag", brk_done_o, 0);
    else          check("R8 break flag sticky", brk_done_o, 1);
    tick_pulse(1'b0);
    check("R8 id flag sticky", id_done_o, 1);
    check("R8 line idle after tick", txd_o, 1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 txd", txd_o, 1);
    check("R12 txrdy", txrdy_o, 1);
    check("R12 brk flag", brk_done_o, 0);
    check("R12 id flag", id_done_o, 0);
  endtask

  task automatic t_slave();
    mode_i = 4'hB;
    write_id(8'h12, 1'b0);
    check("R1 slave txd", txd_o, 1);
    check("R1 slave txrdy", txrdy_o, 1);
    repeat (3) tick_pulse(1'b0);
    check("R1 slave txd later", txd_o, 1);
    check("R1 slave flags", {brk_done_o, id_done_o}, 0);
    mode_i = 4'hA;
    @(negedge clk); tx_rst_i = 1'b1;
    @(negedge clk); tx_rst_i = 1'b0;
  endtask

  task automatic t_abort();
    clear_flags();
    write_id(8'h21, 1'b1);
    repeat (5) tick_pulse(1'b0);
    check("R11 mid break", txd_o, 0);
    @(negedge clk); tx_rst_i = 1'b1;
    @(negedge clk); tx_rst_i = 1'b0;
    check("R11 txd idle", txd_o, 1);
    check("R11 txrdy", txrdy_o, 1);
    repeat (12) tick_pulse(1'b0);
    check("R11 stays idle", txd_o, 1);
    check("R11 no flags", {brk_done_o, id_done_o}, 0);
  endtask

  task automatic t_clear();
    clear_flags();
    check("R9 flags cleared", {brk_done_o, id_done_o}, 0);
  endtask

  initial begin
    t_reset();
    t_slave();
    t_header(8'h3C, 1'b0, 0, 0);
    t_clear();
    t_header(8'h00, 1'b1, 0, 0);
    t_header(8'h3F, 1'b1, 1, 0);
    t_header(8'h1A, 1'b1, 0, 1);
    t_abort();
    t_header(8'hA7, 1'b0, 1, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule